// File: doc/BRIEF.md
# Replay FIFO with Chained Expansion Token

This block is a 9-bit first-in first-out buffer. Its active-low write and read strobes are sampled as synchronous enables on a single clock. Occupancy flags block overrun and underrun. The occupancy count runs from zero to `DEPTH`, and `DEPTH` is a power of two between 256 and 4096 words.

The block has two modes. In standalone mode the shared flag output `hf_xo` shows half occupancy. A rewind input replays stored data from the first word written since reset.

In chained (depth-expansion) mode several devices share one logical buffer. Each device holds a write token and a read token. It accepts strobes only while it holds the matching token. When it uses its last address, it passes that token on by raising a one-cycle pulse on `hf_xo` for the write side or on `xo_rd` for the read side.

Each token is tracked by a small state machine with these states:
- `TK_BOOT`: the first cycle after reset.
- `TK_WAIT`: the device does not hold the token.
- `TK_HOLD`: the device owns the token.
- `TK_HAND`: the one-cycle hand-off pulse.

Its transitions are:
- BOOT to HOLD when `first_dev` is high, otherwise BOOT to WAIT.
- WAIT to HOLD on an incoming token pulse.
- HOLD to HAND when an accepted access targets the last address.
- HAND to WAIT unconditionally.

Top module: `replay_fifo`

## Requirements
- R1: Words are read out in exactly the order they were accepted for writing.
- R2: A write is accepted on a clock edge where `wr_n` is 0, the buffer is not full and, in chained mode, the write token is held. A read is accepted under the same conditions with `rd_n` and the read token, provided the buffer is not empty. An accepted read presents its word on `dout` after that edge, and `dout` holds its value otherwise.
- R3: `dout_oe` is 1 only in the cycle after an edge at which `rd_n` was 0.
- R4: `empty` is 1 exactly when the count is 0, and `full` is 1 exactly when the count equals `DEPTH`. A write while full and a read while empty have no effect.
- R5: An accepted read and an accepted write on the same edge leave the count unchanged.
- R6: In standalone mode (`chain_mode`=0), `hf_xo` is 1 exactly when the count is at least `DEPTH`/2.
- R7: In standalone mode, `rt_n`=0 with `wr_n`=1 and `rd_n`=1 rewinds the read position to address 0. It sets the count to the number of words written since reset, or to `DEPTH` if the write address has wrapped.
- R8: `rt_n` has no effect when either strobe is 0 or when `chain_mode`=1.
- R9: In chained mode, the write token and the read token are each held one cycle after reset if `first_dev`=1. A token is also taken one edge after its input pulse (`xi_wr` or `xi_rd`). Strobes without the matching token are ignored.
- R10: In chained mode, an accepted write to the last address makes `hf_xo` 1 for exactly the next cycle and releases the write token. In this mode `hf_xo` never shows half occupancy.
- R11: In chained mode, an accepted read from the last address makes `xo_rd` 1 for exactly the next cycle and releases the read token.
- R12: After reset, `empty`=1, `full`=0, `hf_xo`=0, `xo_rd`=0, `dout_oe`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_mode | input | 1 | 1 = depth-expansion chain, 0 = standalone |
| first_dev | input | 1 | Device starts with both tokens after reset |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind request, active low |
| din | input | DW | Write data |
| xi_wr | input | 1 | Incoming write-token pulse |
| xi_rd | input | 1 | Incoming read-token pulse |
| dout | output | DW | Read data |
| dout_oe | output | 1 | Output enable for read data |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Buffer full |
| hf_xo | output | 1 | Half-full flag, or write-token hand-off in chained mode |
| xo_rd | output | 1 | Read-token hand-off pulse |

## Verification
Several strobe patterns are applied:
- Write-only runs separate the count rising from the half flag's threshold.
- A combined read-and-write cycle separates a held count from one that moves.
- Filling the buffer past capacity and draining it past empty shows that the extra strobes are dropped and that order is kept.
- Rewind requests alone, with a read strobe, and in chained mode separate an honoured rewind from an ignored one.
- In chained mode, strobes with and without the tokens show gating and the one-cycle hand-off pulses at the last address.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
    typedef enum logic [1:0] {
        TK_BOOT = 2'd0,
        TK_WAIT = 2'd1,
        TK_HOLD = 2'd2,
        TK_HAND = 2'd3
    } token_state_e;
endpackage

// File: rtl/replay_fifo_token.sv
module replay_fifo_token
    import replay_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_own,
    input  logic take,
    input  logic pass,
    output logic own,
    output logic xo
);
    token_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TK_BOOT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TK_BOOT: state_nx = start_own ? TK_HOLD : TK_WAIT;
            TK_WAIT: if (take) state_nx = TK_HOLD;
            TK_HOLD: if (pass) state_nx = TK_HAND;
            TK_HAND: state_nx = TK_WAIT;
            default: state_nx = TK_BOOT;
        endcase
    end

    always_comb begin
        own = (state == TK_HOLD);
        xo  = (state == TK_HAND);
    end

    assert_handoff_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_HAND) |=> (state == TK_WAIT));
    assert_take_grants_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_WAIT && take) |=> own);
endmodule

// File: rtl/replay_fifo_store.sv
module replay_fifo_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_go,
    input  logic                       rd_go,
    input  logic                       rt_go,
    input  logic [DW-1:0]              din,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       wr_last,
    output logic                       rd_last
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wrapped;

    assign wr_last = wr_go && (wr_ptr == LAST);
    assign rd_last = rd_go && (rd_ptr == LAST);

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            wrapped <= 1'b0;
            dout    <= '0;
        end else if (rt_go) begin
            rd_ptr <= '0;
            count  <= wrapped ? CW'(DEPTH) : {1'b0, wr_ptr};
        end else begin
            if (wr_go) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (wr_ptr == LAST) wrapped <= 1'b1;
            end
            if (rd_go) begin
                rd_ptr <= rd_ptr + 1'b1;
                dout   <= mem[rd_ptr];
            end
            unique case ({wr_go, rd_go})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_write_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !rd_go && !rt_go) |=> (count == $past(count) + CW'(1)));
    assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && rd_go && !rt_go) |=> $stable(count));
    assert_rewind_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rt_go |=> (rd_ptr == '0));
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
    parameter int DEPTH = 256,
    parameter int DW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_mode,
    input  logic          first_dev,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          rt_n,
    input  logic [DW-1:0] din,
    input  logic          xi_wr,
    input  logic          xi_rd,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          empty,
    output logic          full,
    output logic          hf_xo,
    output logic          xo_rd
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic [CW-1:0] count;
    logic wr_own, rd_own, wr_xo;
    logic wr_last, rd_last;
    logic wr_go, rd_go, rt_go;

    always_comb begin
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
        wr_go = !wr_n && !full  && (!chain_mode || wr_own);
        rd_go = !rd_n && !empty && (!chain_mode || rd_own);
        rt_go = !rt_n && wr_n && rd_n && !chain_mode;
        hf_xo = chain_mode ? wr_xo : (count >= CW'(HALF));
    end

    replay_fifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_go(wr_go), .rd_go(rd_go), .rt_go(rt_go),
        .din(din), .dout(dout), .count(count),
        .wr_last(wr_last), .rd_last(rd_last)
    );

    replay_fifo_token wr_tok_i (
        .clk(clk), .rst_n(rst_n), .start_own(first_dev),
        .take(chain_mode && xi_wr), .pass(chain_mode && wr_last),
        .own(wr_own), .xo(wr_xo)
    );

    replay_fifo_token rd_tok_i (
        .clk(clk), .rst_n(rst_n), .start_own(first_dev),
        .take(chain_mode && xi_rd), .pass(chain_mode && rd_last),
        .own(rd_own), .xo(xo_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_oe <= 1'b0;
        else        dout_oe <= !rd_n;
    end

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    assert_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_n && rt_n) |=> (empty && $stable(dout)));
endmodule

// File: tb/replay_fifo_tb_top.sv
`timescale 1ns/1ps
module replay_fifo_tb_top;
    localparam int D = 8;
    logic clk = 0, rst_n = 0, chain_mode = 0, first_dev = 0;
    logic wr_n = 1, rd_n = 1, rt_n = 1, xi_wr = 0, xi_rd = 0;
    logic [8:0] din = '0, dout;
    logic dout_oe, empty, full, hf_xo, xo_rd;
    int n_run = 0, n_fail = 0;

    replay_fifo #(.DEPTH(D), .DW(9)) dut_i (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .first_dev(first_dev),
        .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din), .xi_wr(xi_wr), .xi_rd(xi_rd),
        .dout(dout), .dout_oe(dout_oe), .empty(empty), .full(full),
        .hf_xo(hf_xo), .xo_rd(xo_rd)
    );

    always #10 clk = ~clk;

    // vector: {wr_n,rd_n,rt_n}[24:22] din[21:13] {empty,full,hf,oe}[12:9] dout[8:0]
    localparam int NV = 15;
    localparam logic [24:0] VEC [NV] = '{
        {3'b011, 9'h101, 4'b0000, 9'h000},  // R2 write
        {3'b011, 9'h102, 4'b0000, 9'h000},
        {3'b011, 9'h103, 4'b0000, 9'h000},
        {3'b011, 9'h104, 4'b0010, 9'h000},  // R6 count 4
        {3'b101, 9'h000, 4'b0001, 9'h101},  // R1 R6 count 3
        {3'b001, 9'h105, 4'b0001, 9'h102},  // R5 both
        {3'b111, 9'h000, 4'b0000, 9'h000},  // R3 oe low
        {3'b110, 9'h000, 4'b0010, 9'h000},  // R7 rewind, count 5
        {3'b101, 9'h000, 4'b0011, 9'h101},  // R7 replay
        {3'b101, 9'h000, 4'b0001, 9'h102},
        {3'b101, 9'h000, 4'b0001, 9'h103},
        {3'b101, 9'h000, 4'b0001, 9'h104},
        {3'b101, 9'h000, 4'b1001, 9'h105},  // R4 empty
        {3'b101, 9'h000, 4'b1001, 9'h105},  // R4 read at empty ignored
        {3'b111, 9'h000, 4'b1000, 9'h000}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic t, input logic [8:0] d,
                        input logic xw, input logic xr);
        wr_n = w; rd_n = r; rt_n = t; din = d; xi_wr = xw; xi_rd = xr;
        @(posedge clk);
        @(negedge clk);
        wr_n = 1; rd_n = 1; rt_n = 1; xi_wr = 0; xi_rd = 0;
    endtask

    task automatic do_reset(input logic cm, input logic fd);
        @(negedge clk);
        rst_n = 0; chain_mode = cm; first_dev = fd;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0, 1'b0);
        chk("R12 empty", empty, 1); chk("R12 full", full, 0);
        chk("R12 hf_xo", hf_xo, 0); chk("R12 xo_rd", xo_rd, 0);
        chk("R12 oe", dout_oe, 0);  chk("R12 dout", dout, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21:13], 1'b0, 1'b0);
            chk($sformatf("R4 empty v%0d", i), empty, VEC[i][12]);
            chk($sformatf("R4 full v%0d", i), full, VEC[i][11]);
            chk($sformatf("R6 hf v%0d", i), hf_xo, VEC[i][10]);
            chk($sformatf("R3 oe v%0d", i), dout_oe, VEC[i][9]);
            if (VEC[i][9]) chk($sformatf("R1 dout v%0d", i), dout, VEC[i][8:0]);
        end

        // R4/R1: fill past capacity, drain in order
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < D; i++) step(1'b0, 1'b1, 1'b1, 9'(16 + i), 1'b0, 1'b0);
        chk("R4 full at depth", full, 1);
        chk("R6 hf at depth", hf_xo, 1);
        step(1'b0, 1'b1, 1'b1, 9'h1FF, 1'b0, 1'b0);
        chk("R4 write at full ignored", full, 1);
        for (int i = 0; i < D; i++) begin
            step(1'b1, 1'b0, 1'b1, 9'h0, 1'b0, 1'b0);
            chk("R1 drain order", dout, 16 + i);
        end
        chk("R4 empty after drain", empty, 1);

        // R8: rewind with read strobe active is ignored
        do_reset(1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1, 9'h0A1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1, 9'h0A2, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 9'h0, 1'b0, 1'b0);
        chk("R2 first read", dout, 9'h0A1);
        step(1'b1, 1'b0, 1'b0, 9'h0, 1'b0, 1'b0);
        chk("R8 rewind with read ignored", dout, 9'h0A2);
        chk("R8 empty after", empty, 1);

        // chained mode, no initial tokens
        do_reset(1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 9'h0AA, 1'b0, 1'b0);
        chk("R9 write without token", empty, 1);
        step(1'b1, 1'b1, 1'b1, 9'h0, 1'b1, 1'b0);
        for (int i = 0; i < D; i++) begin
            step(1'b0, 1'b1, 1'b1, 9'(48 + i), 1'b0, 1'b0);
            if (i == 3) chk("R10 no half flag in chain", hf_xo, 0);
            if (i == D - 2) chk("R10 no pulse early", hf_xo, 0);
        end
        chk("R10 hand-off pulse", hf_xo, 1);
        chk("R4 full in chain", full, 1);
        step(1'b1, 1'b1, 1'b1, 9'h0, 1'b0, 1'b0);
        chk("R10 pulse one cycle", hf_xo, 0);
        step(1'b1, 1'b0, 1'b1, 9'h0, 1'b0, 1'b0);
        chk("R11 read without token", full, 1);
        step(1'b1, 1'b1, 1'b1, 9'h0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1, 9'h0, 1'b0, 1'b0);
        chk("R9 read with token", dout, 48);
        step(1'b1, 1'b0, 1'b1, 9'h0, 1'b0, 1'b0);
        chk("R1 chain order", dout, 49);
        step(1'b1, 1'b1, 1'b0, 9'h0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 9'h0, 1'b0, 1'b0);
        chk("R8 no rewind in chain", dout, 50);
        for (int i = 3; i < D; i++) begin
            step(1'b1, 1'b0, 1'b1, 9'h0, 1'b0, 1'b0);
            if (i < D - 1) chk("R11 no pulse early", xo_rd, 0);
        end
        chk("R11 hand-off pulse", xo_rd, 1);
        chk("R11 last word", dout, 48 + D - 1);
        chk("R4 empty after chain drain", empty, 1);
        step(1'b1, 1'b1, 1'b1, 9'h0, 1'b0, 1'b0);
        chk("R11 pulse one cycle", xo_rd, 0);
        step(1'b0, 1'b1, 1'b1, 9'h0BB, 1'b0, 1'b0);
        chk("R10 write token released", empty, 1);

        // chained mode, first device
        do_reset(1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 9'h0CC, 1'b0, 1'b0);
        chk("R9 first device writes", empty, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule